// File: doc/BRIEF.md
# SMM Memory Steering Controller

This block decides where each memory access lands when parts of the address space are reserved for system-management mode (SMM). Two byte-wide control registers and one 16-bit size register sit behind a single 32-bit configuration word. The configuration word is written with per-byte enables. From these registers, the access address and a flag that marks an SMM access, the block picks one of three destinations. Main RAM (with a translated RAM address), the I/O bus, or a blackhole. A blackhole means reads return all ones and writes are dropped.

Three protected regions are steered:
- A 128 KiB legacy window at 0x000A0000.
- A 128 KiB high alias of that same RAM at 0xFEDA0000.
- A reserved top segment that ends at the top of low memory. Its size is selectable, and one size code draws on a megabyte count fixed at build time. Firmware can discover that count through the size register.

A one-way lock closes the ordinary-mode view and freezes both control registers until reset. The routing outputs are combinational from the registered state and the address.

Top module: `smm_route_ctrl`

## Requirements
- R1: After reset the configuration word reads 0xFFFF0000: both control bytes are 0 and the size register holds the query value 0xFFFF (0x0000 when the build-time megabyte count is 0). With that state the legacy window routes to the bus for both kinds of access.
- R2: Word layout is: bits [7:0] window control, bits [15:8] segment control, bits [31:16] size register. Only byte lanes whose enable is 1 are written. Unlocked, the writable window bits are 0x07 and the writable segment bits are 0x0F; all other bits read 0.
- R3: Window control bit 1 is the lock. In any update that leaves the lock set, bit 0 (open) is forced to 0. While locked, writes leave both control bytes unchanged until reset.
- R4: For an ordinary access in the legacy window, the route is RAM only when open (window bit 0) is 1 and high-enable (segment bit 3) is 0. Otherwise it is the bus.
- R5: For an ordinary access in the high alias window, the route is RAM only when open is 1 and high-enable is 1, and the RAM address is the address minus 0xFEDA0000 plus 0x000A0000. Otherwise it is the bus.
- R6: When global enable (window bit 2) is 1, an SMM access sees RAM in the legacy window if high-enable is 0, or in the high alias if high-enable is 1. In every other case an SMM access in either window follows the ordinary rule.
- R7: The top segment is active only when segment-enable (segment bit 0) and global enable are both 1. Its size code (segment bits [2:1]) selects 0 = 1 MiB, 1 = 2 MiB, 2 = 8 MiB, 3 = the build-time megabyte count.
- R8: An active segment covers addresses from (top of low memory - size) up to, but not including, the top of low memory. There an ordinary access routes to the blackhole (code 2) and an SMM access to RAM; addresses outside it are not affected.
- R9: A write that touches the size register and leaves it equal to 0xFFFF makes it read the build-time megabyte count. Any other written value is stored as written. The lock has no effect on this register.
- R10: Route codes are 0 = bus, 1 = RAM, 2 = blackhole. Outside the windows and the segment, addresses below the top of low memory route to RAM and the rest to the bus. In both cases the RAM address equals the access address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tolm_i | input | ADDR_W | Top of low memory, static |
| cfg_wr_i | input | 1 | Configuration word write strobe |
| cfg_be_i | input | 4 | Byte-lane enables for the write |
| cfg_wdata_i | input | 32 | Configuration write data |
| cfg_rdata_o | output | 32 | Current configuration word |
| acc_addr_i | input | ADDR_W | Access address |
| acc_smm_i | input | 1 | Access is made in SMM |
| route_o | output | 2 | Destination code |
| ram_addr_o | output | ADDR_W | Address presented to RAM |

## Verification
A configuration write is taken at one rising edge. Its effect on the read-back word and on the routing outputs is due just after that edge, with no further register on either path. The bench therefore drives a write on a falling edge and compares the configuration word on the next falling edge. An address or mode change has no edge at all between stimulus and result. The bench applies it on a falling edge and compares one nanosecond later, well before the next rising edge.

// File: rtl/smm_route_pkg.sv
package smm_route_pkg;

   typedef enum logic [1:0] {
      ROUTE_BUS  = 2'd0,
      ROUTE_RAM  = 2'd1,
      ROUTE_HOLE = 2'd2
   } route_e;

   // window control byte
   localparam int unsigned WIN_OPEN_BIT = 0;
   localparam int unsigned WIN_LOCK_BIT = 1;
   localparam int unsigned WIN_GEN_BIT  = 2;

   // segment control byte
   localparam int unsigned SEG_EN_BIT   = 0;
   localparam int unsigned SEG_SZ_LSB   = 1;
   localparam int unsigned SEG_HIGH_BIT = 3;

   localparam logic [7:0] WIN_WMASK_OPEN   = 8'h07;
   localparam logic [7:0] WIN_WMASK_LOCKED = 8'h00;
   localparam logic [7:0] SEG_WMASK_OPEN   = 8'h0F;
   localparam logic [7:0] SEG_WMASK_LOCKED = 8'h00;

   localparam logic [31:0] LOW_WIN_BASE  = 32'h000A_0000;
   localparam logic [31:0] HIGH_WIN_BASE = 32'hFEDA_0000;
   localparam logic [31:0] WIN_BYTES     = 32'h0002_0000;
   localparam int unsigned MIB_SHIFT     = 20;
   localparam int unsigned EXT_MB_LIMIT  = 4095;

   typedef struct packed {
      logic       high_en;
      logic [1:0] seg_size;
      logic       seg_en;
      logic       glob_en;
      logic       locked;
      logic       open;
   } smm_ctl_t;

endpackage

// File: rtl/smm_ctl_regs.sv
module smm_ctl_regs
   import smm_route_pkg::*;
#(
   parameter logic [7:0] WIN_WMASK     = WIN_WMASK_OPEN,
   parameter logic [7:0] WIN_WMASK_LCK = WIN_WMASK_LOCKED,
   parameter logic [7:0] SEG_WMASK     = SEG_WMASK_OPEN,
   parameter logic [7:0] SEG_WMASK_LCK = SEG_WMASK_LOCKED
)(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_i,
   input  logic [1:0] be_i,
   input  logic [15:0] wdata_i,
   output logic [7:0] win_q_o,
   output logic [7:0] seg_q_o,
   output smm_ctl_t   ctl_o
);

   if (WIN_WMASK[WIN_LOCK_BIT] == 1'b0) begin : g_chk_lock_wr
      $error("lock bit must be writable while unlocked");
   end
   if (WIN_WMASK_LCK[WIN_LOCK_BIT] != 1'b0 || WIN_WMASK_LCK[WIN_OPEN_BIT] != 1'b0) begin : g_chk_lck_mask
      $error("locked window mask may not reopen or unlock");
   end

   logic [7:0] win_q, win_d, seg_q, seg_d;
   logic [7:0] win_mask, seg_mask;
   logic       locked;

   assign locked   = win_q[WIN_LOCK_BIT];
   assign win_mask = locked ? WIN_WMASK_LCK : WIN_WMASK;
   assign seg_mask = locked ? SEG_WMASK_LCK : SEG_WMASK;

   always_comb begin
      win_d = win_q;
      seg_d = seg_q;
      if (wr_i && be_i[0]) begin
         win_d = (win_q & ~win_mask) | (wdata_i[7:0] & win_mask);
      end
      if (wr_i && be_i[1]) begin
         seg_d = (seg_q & ~seg_mask) | (wdata_i[15:8] & seg_mask);
      end
      if (win_d[WIN_LOCK_BIT]) begin
         win_d[WIN_OPEN_BIT] = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         win_q <= '0;
         seg_q <= '0;
      end else begin
         win_q <= win_d;
         seg_q <= seg_d;
      end
   end

   assign win_q_o = win_q;
   assign seg_q_o = seg_q;

   always_comb begin
      ctl_o          = '0;
      ctl_o.open     = win_q[WIN_OPEN_BIT];
      ctl_o.locked   = win_q[WIN_LOCK_BIT];
      ctl_o.glob_en  = win_q[WIN_GEN_BIT];
      ctl_o.seg_en   = seg_q[SEG_EN_BIT];
      ctl_o.seg_size = seg_q[SEG_SZ_LSB +: 2];
      ctl_o.high_en  = seg_q[SEG_HIGH_BIT];
   end

   AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      locked |=> locked); // R3
   AST_LOCK_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
      locked |-> !win_q[WIN_OPEN_BIT]); // R3
   AST_LOCKED_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (locked && wr_i) |=> ((((win_q ^ $past(win_q)) & ~WIN_WMASK_LCK) == 8'h00) &&
                            (((seg_q ^ $past(seg_q)) & ~SEG_WMASK_LCK) == 8'h00))); // R3
   AST_UNWRITABLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      ((win_q & ~WIN_WMASK) == 8'h00) && ((seg_q & ~SEG_WMASK) == 8'h00)); // R2

endmodule

// File: rtl/smm_ext_size_reg.sv
module smm_ext_size_reg #(
   parameter int unsigned EXT_MB = 16,
   parameter int unsigned EXT_W  = 16
)(
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wr_i,
   input  logic [EXT_W/8-1:0]     be_i,
   input  logic [EXT_W-1:0]       wdata_i,
   output logic [EXT_W-1:0]       q_o
);

   localparam int unsigned    LANES = EXT_W / 8;
   localparam logic [EXT_W-1:0] QUERY = '1;
   localparam logic [EXT_W-1:0] RST_VAL = (EXT_MB > 0) ? QUERY : '0;

   if (EXT_W % 8 != 0 || EXT_W == 0) begin : g_chk_width
      $error("size register width must be whole bytes");
   end
   if (EXT_MB >= (2 ** EXT_W) - 1) begin : g_chk_answer
      $error("megabyte count collides with query value");
   end

   logic [EXT_W-1:0] q, d, merged;
   logic             touched;

   assign touched = wr_i && (|be_i);

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      assign merged[l*8 +: 8] = be_i[l] ? wdata_i[l*8 +: 8] : q[l*8 +: 8];
   end

   if (EXT_MB > 0) begin : g_query
      localparam logic [EXT_W-1:0] ANSWER = EXT_W'(EXT_MB);
      assign d = !touched ? q : ((merged == QUERY) ? ANSWER : merged);

      AST_QUERY_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
         touched |=> (q != QUERY)); // R9
   end else begin : g_plain
      assign d = touched ? merged : q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= RST_VAL;
      else        q <= d;
   end

   assign q_o = q;

endmodule

// File: rtl/smm_seg_size.sv
module smm_seg_size
   import smm_route_pkg::*;
#(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned EXT_MB = 16
)(
   input  logic [1:0]        code_i,
   output logic [ADDR_W-1:0] bytes_o
);

   localparam logic [ADDR_W-1:0] ONE_MIB   = ADDR_W'(1) << MIB_SHIFT;
   localparam logic [ADDR_W-1:0] TWO_MIB   = ADDR_W'(2) << MIB_SHIFT;
   localparam logic [ADDR_W-1:0] EIGHT_MIB = ADDR_W'(8) << MIB_SHIFT;

   logic [ADDR_W-1:0] ext_bytes;

   if (EXT_MB == 0) begin : g_no_ext
      assign ext_bytes = '0;
   end else begin : g_ext
      assign ext_bytes = ADDR_W'(EXT_MB) << MIB_SHIFT;
   end

   always_comb begin
      unique case (code_i)
         2'd0:    bytes_o = ONE_MIB;
         2'd1:    bytes_o = TWO_MIB;
         2'd2:    bytes_o = EIGHT_MIB;
         default: bytes_o = ext_bytes;
      endcase
   end

endmodule

// File: rtl/smm_route_decode.sv
module smm_route_decode
   import smm_route_pkg::*;
#(
   parameter int unsigned ADDR_W = 32
)(
   input  logic              open_i,
   input  logic              glob_en_i,
   input  logic              high_en_i,
   input  logic              seg_en_i,
   input  logic [ADDR_W-1:0] seg_bytes_i,
   input  logic [ADDR_W-1:0] tolm_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              smm_i,
   output route_e            route_o,
   output logic [ADDR_W-1:0] ram_addr_o
);

   localparam logic [ADDR_W-1:0] LO_BASE = ADDR_W'(LOW_WIN_BASE);
   localparam logic [ADDR_W-1:0] LO_END  = ADDR_W'(LOW_WIN_BASE + WIN_BYTES);
   localparam logic [ADDR_W-1:0] HI_BASE = ADDR_W'(HIGH_WIN_BASE);
   localparam logic [ADDR_W-1:0] HI_END  = ADDR_W'(HIGH_WIN_BASE + WIN_BYTES);

   logic              lo_hit, hi_hit, seg_act, seg_hit;
   logic              see_ram, lo_ram, hi_ram;
   logic [ADDR_W-1:0] seg_base;

   assign lo_hit   = (addr_i >= LO_BASE) && (addr_i < LO_END);
   assign hi_hit   = (addr_i >= HI_BASE) && (addr_i < HI_END);
   assign seg_act  = seg_en_i && glob_en_i && (seg_bytes_i != '0);
   assign seg_base = tolm_i - seg_bytes_i;
   assign seg_hit  = seg_act && (addr_i >= seg_base) && (addr_i < tolm_i);

   // ordinary view opens with the open bit; SMM adds the global enable
   assign see_ram  = open_i || (smm_i && glob_en_i);
   assign lo_ram   = see_ram && !high_en_i;
   assign hi_ram   = see_ram &&  high_en_i;

   always_comb begin
      route_o    = ROUTE_BUS;
      ram_addr_o = addr_i;
      if (hi_hit) begin
         if (hi_ram) begin
            route_o    = ROUTE_RAM;
            ram_addr_o = addr_i - HI_BASE + LO_BASE;
         end
      end else if (lo_hit) begin
         if (lo_ram) route_o = ROUTE_RAM;
      end else if (seg_hit) begin
         route_o = smm_i ? ROUTE_RAM : ROUTE_HOLE;
      end else if (addr_i < tolm_i) begin
         route_o = ROUTE_RAM;
      end
   end

endmodule

// File: rtl/smm_route_ctrl.sv
module smm_route_ctrl
   import smm_route_pkg::*;
#(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned EXT_MB = 16
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] tolm_i,
   input  logic              cfg_wr_i,
   input  logic [3:0]        cfg_be_i,
   input  logic [31:0]       cfg_wdata_i,
   output logic [31:0]       cfg_rdata_o,
   input  logic [ADDR_W-1:0] acc_addr_i,
   input  logic              acc_smm_i,
   output logic [1:0]        route_o,
   output logic [ADDR_W-1:0] ram_addr_o
);

   localparam int unsigned EXT_W = 16;

   if (ADDR_W < 32) begin : g_chk_aw
      $error("address width must cover the high alias window");
   end
   if (EXT_MB > EXT_MB_LIMIT) begin : g_chk_ext
      $error("megabyte count too large");
   end

   logic [7:0]        win_q, seg_q;
   logic [EXT_W-1:0]  ext_q;
   smm_ctl_t          ctl;
   logic [ADDR_W-1:0] seg_bytes;
   route_e            route;

   smm_ctl_regs u_ctl (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_i    (cfg_wr_i),
      .be_i    (cfg_be_i[1:0]),
      .wdata_i (cfg_wdata_i[15:0]),
      .win_q_o (win_q),
      .seg_q_o (seg_q),
      .ctl_o   (ctl)
   );

   smm_ext_size_reg #(.EXT_MB(EXT_MB), .EXT_W(EXT_W)) u_ext (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_i    (cfg_wr_i),
      .be_i    (cfg_be_i[3:2]),
      .wdata_i (cfg_wdata_i[31:16]),
      .q_o     (ext_q)
   );

   smm_seg_size #(.ADDR_W(ADDR_W), .EXT_MB(EXT_MB)) u_size (
      .code_i  (ctl.seg_size),
      .bytes_o (seg_bytes)
   );

   smm_route_decode #(.ADDR_W(ADDR_W)) u_dec (
      .open_i      (ctl.open),
      .glob_en_i   (ctl.glob_en),
      .high_en_i   (ctl.high_en),
      .seg_en_i    (ctl.seg_en),
      .seg_bytes_i (seg_bytes),
      .tolm_i      (tolm_i),
      .addr_i      (acc_addr_i),
      .smm_i       (acc_smm_i),
      .route_o     (route),
      .ram_addr_o  (ram_addr_o)
   );

   assign cfg_rdata_o = {ext_q, seg_q, win_q};
   assign route_o     = route;

   // independent window decode used only by the checks below
   logic ast_lo, ast_hi;
   assign ast_lo = (acc_addr_i >= ADDR_W'(LOW_WIN_BASE)) &&
                   (acc_addr_i <  ADDR_W'(LOW_WIN_BASE + WIN_BYTES));
   assign ast_hi = (acc_addr_i >= ADDR_W'(HIGH_WIN_BASE)) &&
                   (acc_addr_i <  ADDR_W'(HIGH_WIN_BASE + WIN_BYTES));

   AST_ROUTE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      route_o != 2'd3); // R10
   AST_HOLE_ORDINARY: assert property (@(posedge clk) disable iff (!rst_n)
      (route_o == 2'd2) |-> (!acc_smm_i && ctl.seg_en && ctl.glob_en)); // R8
   AST_CLOSED_LOW_BUS: assert property (@(posedge clk) disable iff (!rst_n)
      (ast_lo && !acc_smm_i && !ctl.open) |-> (route_o == 2'd0)); // R4
   AST_ALIAS_LANDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (ast_hi && route_o == 2'd1) |->
         (ram_addr_o >= ADDR_W'(LOW_WIN_BASE) &&
          ram_addr_o <  ADDR_W'(LOW_WIN_BASE + WIN_BYTES))); // R5
   AST_SMM_HIGH_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
      (ast_hi && acc_smm_i && ctl.glob_en && ctl.high_en) |-> (route_o == 2'd1)); // R6

endmodule

// File: tb/test_smm_route_ctrl.sv
`timescale 1ns/1ps
module test_smm_route_ctrl;

   localparam int unsigned AW     = 32;
   localparam int unsigned EXT_MB = 16;
   localparam logic [31:0] TOLM   = 32'h7000_0000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_wr = 1'b0;
   logic [3:0]  cfg_be = '0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] cfg_rdata;
   logic [31:0] acc_addr = '0;
   logic        acc_smm = 1'b0;
   logic [1:0]  route;
   logic [31:0] ram_addr;

   always #2.5 clk = ~clk;

   smm_route_ctrl #(.ADDR_W(AW), .EXT_MB(EXT_MB)) i_smm_route_ctrl (
      .clk(clk), .rst_n(rst_n), .tolm_i(TOLM),
      .cfg_wr_i(cfg_wr), .cfg_be_i(cfg_be), .cfg_wdata_i(cfg_wdata),
      .cfg_rdata_o(cfg_rdata), .acc_addr_i(acc_addr), .acc_smm_i(acc_smm),
      .route_o(route), .ram_addr_o(ram_addr)
   );

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   logic [7:0]  m_win;
   logic [7:0]  m_seg;
   logic [15:0] m_ext;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // expected {route, ram_addr} from the requirements
   function automatic logic [33:0] m_access(input logic [31:0] a, input logic smm);
      logic open, gen, sen, hi, see, act;
      logic [31:0] mb, bytes, base;
      logic [1:0]  r;
      logic [31:0] ra;
      open = m_win[0]; gen = m_win[2]; sen = m_seg[0]; hi = m_seg[3];
      case (m_seg[2:1])
         2'd0: mb = 1;
         2'd1: mb = 2;
         2'd2: mb = 8;
         default: mb = EXT_MB;
      endcase
      bytes = mb << 20;
      base  = TOLM - bytes;
      act   = sen && gen && (bytes != 0);
      see   = open || (smm && gen);
      r  = 2'd0;
      ra = a;
      if (a >= 32'hFEDA_0000 && a < 32'hFEDC_0000) begin
         if (see && hi) begin r = 2'd1; ra = a - 32'hFEDA_0000 + 32'h000A_0000; end
      end else if (a >= 32'h000A_0000 && a < 32'h000C_0000) begin
         if (see && !hi) r = 2'd1;
      end else if (act && a >= base && a < TOLM) begin
         r = smm ? 2'd1 : 2'd2;
      end else if (a < TOLM) begin
         r = 2'd1;
      end
      return {r, ra};
   endfunction

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      m_win = 8'h00; m_seg = 8'h00; m_ext = 16'hFFFF;
   endtask

   task automatic do_write(input logic [3:0] be, input logic [31:0] d);
      logic [7:0]  wm0, wm1;
      logic [15:0] nx;
      @(negedge clk);
      cfg_wr = 1'b1; cfg_be = be; cfg_wdata = d;
      @(negedge clk);
      cfg_wr = 1'b0; cfg_be = '0;
      wm0 = m_win[1] ? 8'h00 : 8'h07;
      wm1 = m_win[1] ? 8'h00 : 8'h0F;
      if (be[0]) m_win = (m_win & ~wm0) | (d[7:0] & wm0);
      if (be[1]) m_seg = (m_seg & ~wm1) | (d[15:8] & wm1);
      if (m_win[1]) m_win[0] = 1'b0;
      if (be[2] || be[3]) begin
         nx = m_ext;
         if (be[2]) nx[7:0]  = d[23:16];
         if (be[3]) nx[15:8] = d[31:24];
         if (nx == 16'hFFFF) nx = 16'(EXT_MB);
         m_ext = nx;
      end
   endtask

   task automatic chk_cfg(input string req);
      chk(req, cfg_rdata, {m_ext, m_seg, m_win});
   endtask

   task automatic probe(input logic [31:0] a, input logic smm, input string req);
      logic [33:0] e;
      acc_addr = a; acc_smm = smm;
      #1;
      e = m_access(a, smm);
      chk({req, " route"}, {30'd0, route}, {30'd0, e[33:32]});
      chk({req, " ram_addr"}, ram_addr, e[31:0]);
   endtask

   initial begin
      logic [31:0] szb;
      logic [31:0] a;
      void'($urandom(32'd4711));
      do_reset();

      // R1 reset state
      chk("R1 reset word", cfg_rdata, 32'hFFFF_0000);
      @(negedge clk);
      acc_addr = 32'h000A_8000; acc_smm = 1'b0; #1;
      chk("R1 low window ordinary", {30'd0, route}, 32'd0);
      acc_smm = 1'b1; #1;
      chk("R1 low window smm", {30'd0, route}, 32'd0);

      // R2 byte lanes and masks
      do_write(4'b0001, 32'hAAAA_AAFD);
      chk("R2 window lane", cfg_rdata, 32'hFFFF_0005);
      do_write(4'b0010, 32'h0000_FF00);
      chk("R2 segment lane", cfg_rdata, 32'hFFFF_0F05);
      chk_cfg("R2 model");

      // R4 R5 R6 window matrix
      do_write(4'b0011, 32'h0000_0000);
      for (int c = 0; c < 8; c++) begin
         do_write(4'b0011, {16'h0, 4'h0, c[2], 3'b000, 5'h0, c[1], 1'b0, c[0]});
         chk_cfg("R2 matrix cfg");
         @(negedge clk);
         probe(32'h000A_0000, 1'b0, "R4 low base");
         probe(32'h000B_FFFF, 1'b0, "R4 low last");
         probe(32'h000C_0000, 1'b0, "R10 past low");
         probe(32'h0009_FFFF, 1'b1, "R10 below low");
         probe(32'hFEDA_0000, 1'b0, "R5 high base");
         probe(32'hFEDB_FFF0, 1'b0, "R5 high last");
         probe(32'hFEDC_0000, 1'b0, "R10 past high");
         probe(32'h000A_1234, 1'b1, "R6 smm low");
         probe(32'hFEDA_1234, 1'b1, "R6 smm high");
      end
      // explicit alias translation R5
      do_write(4'b0011, 32'h0000_0801);
      @(negedge clk);
      acc_addr = 32'hFEDA_4000; acc_smm = 1'b0; #1;
      chk("R5 alias route", {30'd0, route}, 32'd1);
      chk("R5 alias translate", ram_addr, 32'h000A_4000);

      // R7 R8 segment sizes and edges
      for (int code = 0; code < 4; code++) begin
         do_write(4'b0011, {16'h0, 4'h0, 1'b0, code[1:0], 1'b1, 8'h04});
         szb = (code == 0) ? 32'h0010_0000 : (code == 1) ? 32'h0020_0000 :
               (code == 2) ? 32'h0080_0000 : (EXT_MB << 20);
         @(negedge clk);
         acc_addr = TOLM - szb; acc_smm = 1'b0; #1;
         chk("R7 size edge hole", {30'd0, route}, 32'd2);
         acc_addr = TOLM - szb - 1; #1;
         chk("R7 below segment", {30'd0, route}, 32'd1);
         probe(TOLM - 1, 1'b0, "R8 last ordinary");
         probe(TOLM - 1, 1'b1, "R8 last smm");
         probe(TOLM, 1'b0, "R8 tolm");
         probe(TOLM - szb, 1'b1, "R8 base smm");
      end
      do_write(4'b0001, 32'h0000_0000);
      @(negedge clk);
      acc_addr = TOLM - 1; acc_smm = 1'b0; #1;
      chk("R7 no global no hole", {30'd0, route}, 32'd1);

      // R10 default map
      probe(32'h0000_1000, 1'b0, "R10 low ram");
      probe(32'hFFFF_FFF0, 1'b1, "R10 top bus");

      // R9 size register
      chk("R9 reset query", {16'h0, cfg_rdata[31:16]}, 32'h0000_FFFF);
      do_write(4'b1100, 32'hFFFF_0000);
      chk("R9 query answered", {16'h0, cfg_rdata[31:16]}, EXT_MB);
      do_write(4'b1100, 32'h12FF_0000);
      chk("R9 stored", {16'h0, cfg_rdata[31:16]}, 32'h0000_12FF);
      do_write(4'b1000, 32'hFF00_0000);
      chk("R9 partial query", {16'h0, cfg_rdata[31:16]}, EXT_MB);
      chk_cfg("R9 model");

      // R3 lock
      do_write(4'b0011, 32'h0000_0807);
      chk("R3 lock closes", {24'h0, cfg_rdata[7:0]}, 32'h0000_0006);
      do_write(4'b0011, 32'h0000_0001);
      chk("R3 frozen", {16'h0, cfg_rdata[15:0]}, 32'h0000_0806);
      @(negedge clk);
      acc_addr = 32'hFEDA_0100; acc_smm = 1'b0; #1;
      chk("R3 high closed", {30'd0, route}, 32'd0);
      do_write(4'b1100, 32'h0042_0000);
      chk("R9 lock no effect", {16'h0, cfg_rdata[31:16]}, 32'h0000_0042);
      do_reset();
      chk("R3 reset unlocks", cfg_rdata, 32'hFFFF_0000);

      // constrained random
      for (int it = 0; it < 400; it++) begin
         logic [31:0] d;
         logic [3:0]  be;
         if (it % 100 == 99) do_reset();
         d  = $urandom;
         be = 4'($urandom);
         if ($urandom_range(0, 19) != 0) d[1] = 1'b0;
         if ($urandom_range(0, 3) == 0) d[31:16] = 16'hFFFF;
         do_write(be, d);
         chk_cfg("R2 R3 R9 random cfg");
         for (int p = 0; p < 3; p++) begin
            case ($urandom_range(0, 3))
               0: a = 32'h000A_0000 + $urandom_range(0, 32'h1FFFF);
               1: a = 32'hFEDA_0000 + $urandom_range(0, 32'h1FFFF);
               2: a = TOLM - 32'h0120_0000 + $urandom_range(0, 32'h0130_0000);
               default: a = $urandom;
            endcase
            @(negedge clk);
            probe(a, 1'($urandom), "R4 R5 R6 R8 R10 random");
         end
      end

      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule